// File: doc/BRIEF.md
# I2C Bank Control Register Slave

This block is a write-only I2C target that owns a single 8-bit control word steering four switch banks. Each bank reads two bits of the word: a mode bit and a select bit. SCL and SDA are sampled in the system clock domain, which must run at least ten times faster than SCL. The block answers one of four addresses, picked by two strap inputs. It acknowledges the address and exactly one data byte. It holds that byte aside and moves it to the live outputs only when the controller closes the transfer with STOP.

The protocol engine is a state machine with six states. IDLE waits for START. ADDR shifts in the address byte. On the eighth SCL fall, ADDR goes to ADDR_ACK when the address and write direction match, and to SKIP otherwise. ADDR_ACK pulls SDA low for the ninth clock and then moves to DATA on that clock's fall. DATA shifts in the control byte, places it in the shadow register and moves to DATA_ACK. DATA_ACK acknowledges the byte and then moves to SKIP. SKIP ignores everything until the bus state changes. From any state, START restarts ADDR and STOP returns to IDLE. STOP commits the shadow only if a whole data byte arrived after the most recent START.

Top module: `i2c_bank_ctl`

## Requirements
- R1: After reset, `ctl_o` is 0xAA (every mode bit 1, every select bit 0) and `sda_pull_o` is 0.
- R2: START is SDA falling while SCL is high. A write address byte is the seven bits 1,1,0,1,1,strap[1],strap[0], followed by R/W = 0. It is acknowledged by holding SDA low across the ninth SCL high phase.
- R3: An address byte whose seven address bits differ from the expected value gets no acknowledge, and `ctl_o` keeps its value after the following STOP.
- R4: A matching address with R/W = 1 gets no acknowledge, and `ctl_o` keeps its value after the following STOP.
- R5: The data byte after an acknowledged address is acknowledged, and `ctl_o` does not change before STOP.
- R6: STOP (SDA rising while SCL is high) after a complete data byte copies that byte to `ctl_o`. Bank k reads its select bit at bit 2k and its mode bit at bit 2k+1.
- R7: Bytes after the first data byte are not acknowledged (SDA stays high) and are not stored. The first data byte is still the one committed at STOP.
- R8: A STOP inside the data byte discards the partial bits and leaves `ctl_o` unchanged.
- R9: A repeated START in the middle of a byte discards the partial bits. The transfer that follows is decoded from its address onward.
- R10: Each of the four strap settings selects its own address, and only that address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level (wired bus value) |
| strap_i | input | 2 | Address strap, low two address bits |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| ctl_o | output | 8 | Live control word for four banks |

## Verification
A wrong state in the FSM shows up at the ports within one byte time. It appears as an acknowledge on the wrong ninth clock, an acknowledge that is missing, or SDA pulled on an extra byte. The bench samples the wired SDA in the middle of every ninth-clock high phase. A wrong bit counter or shadow value stays hidden until STOP, so every scenario reads `ctl_o` both before and after STOP. Aborted and repeated-START cases must leave the previous word or commit the exact new one.

// File: rtl/i2c_bank_ctl_pkg.sv
package i2c_bank_ctl_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int STRAP_W   = 2;
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_e;

endpackage

// File: rtl/i2c_bank_ctl_sync.sv
module i2c_bank_ctl_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/i2c_bank_ctl_cond.sv
module i2c_bank_ctl_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_bank_ctl_fsm.sv
module i2c_bank_ctl_fsm
    import i2c_bank_ctl_pkg::*;
#(
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b11011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull,
    output logic               byte_done,
    output logic [BYTE_W-1:0]  byte_val
);

    bus_state_e         state_q;
    bus_state_e         state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  sreg;
    logic               hi_seen;
    logic               full;
    logic               addr_ok;

    assign full    = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_ok = (sreg[BYTE_W-1:1] == {ADDR_HI, strap_i}) && !sreg[0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && full) state_d = addr_ok ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall && hi_seen) state_d = ST_DATA;
                ST_DATA:     if (scl_fall && full) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall && hi_seen) state_d = ST_SKIP;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift register, bit counter, ack-clock tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sreg    <= '0;
            hi_seen <= 1'b0;
        end else if (start_det || (state_d != state_q)) begin
            bit_cnt <= '0;
            hi_seen <= 1'b0;
        end else if (scl_rise) begin
            if ((state_q == ST_ADDR || state_q == ST_DATA) && !full) begin
                sreg    <= {sreg[BYTE_W-2:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state_q == ST_ADDR_ACK || state_q == ST_DATA_ACK) begin
                hi_seen <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull  = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);
        byte_done = (state_q == ST_DATA) && (state_d == ST_DATA_ACK);
        byte_val  = sreg;
    end

    // R2: acknowledge drive only begins right after an SCL fall
    p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall));

    // R9: START always restarts bit counting
    p_start_clears_cnt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bit_cnt == '0));

    // R7: the counter never runs past one byte
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/i2c_bank_ctl_reg.sv
module i2c_bank_ctl_reg #(
    parameter int              BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] RST_VAL = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              start_det,
    input  logic              stop_det,
    output logic [BYTE_W-1:0] ctl_o
);

    logic [BYTE_W-1:0] shadow;
    logic              pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= RST_VAL;
            pend   <= 1'b0;
            ctl_o  <= RST_VAL;
        end else begin
            if (byte_done) begin
                shadow <= byte_val;
                pend   <= 1'b1;
            end else if (start_det) begin
                pend   <= 1'b0;
            end else if (stop_det) begin
                pend   <= 1'b0;
                if (pend) ctl_o <= shadow;
            end
        end
    end

    // R6: live word moves only on the cycle after STOP
    p_ctl_at_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_o) |-> $past(stop_det));

    // R8: live word moves only when a full byte was pending
    p_ctl_needs_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_o) |-> $past(pend));

endmodule

// File: rtl/i2c_bank_ctl.sv
module i2c_bank_ctl
    import i2c_bank_ctl_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] CTL_RESET  = 8'hAA
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic [BYTE_W-1:0]  ctl_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;

    i2c_bank_ctl_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_in, sda_in}),
        .q_o   ({scl_s, sda_s})
    );

    i2c_bank_ctl_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bank_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .strap_i   (strap_i),
        .sda_pull  (sda_pull_o),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    i2c_bank_ctl_reg #(
        .BYTE_W  (BYTE_W),
        .RST_VAL (CTL_RESET)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ctl_o     (ctl_o)
    );

    // R2: the acknowledge level never changes while sampled SCL stays high
    p_pull_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull_o));

endmodule

// File: tb/i2c_bank_ctl_bench.sv
module i2c_bank_ctl_bench;

    localparam int Q = 10;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b11;
    logic       sda_pull;
    logic [7:0] ctl_q;
    logic       sda_line;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_bank_ctl u_i2c_bank_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .strap_i    (strap),
        .sda_pull_o (sda_pull),
        .ctl_o      (ctl_q)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wq(Q);
            scl_m = 1'b1;   wq(2*Q);
            scl_m = 1'b0;   wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line;
        wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    function automatic logic [7:0] wr_addr(input logic [1:0] s);
        return {5'b11011, s, 1'b0};
    endfunction

    task automatic t_reset();
        chk("R1", "ctl after reset", ctl_q, 8'hAA);
        chk("R1", "pull after reset", {7'b0, sda_pull}, 8'h00);
    endtask

    task automatic t_basic();
        logic a, d;
        strap = 2'b11;
        bus_start();
        send_byte(wr_addr(2'b11), a);
        chk("R2", "address ack", {7'b0, a}, 8'h01);
        send_byte(8'h35, d);
        chk("R5", "data ack", {7'b0, d}, 8'h01);
        chk("R5", "ctl before stop", ctl_q, 8'hAA);
        bus_stop();
        chk("R6", "ctl after stop", ctl_q, 8'h35);
        chk("R6", "bank2 mode bit5", {7'b0, ctl_q[5]}, 8'h01);
        chk("R6", "bank0 select bit0", {7'b0, ctl_q[0]}, 8'h01);
    endtask

    task automatic t_wrong_addr();
        logic a, d;
        bus_start();
        send_byte({7'b1101110, 1'b0}, a);
        chk("R3", "mismatch address ack", {7'b0, a}, 8'h00);
        send_byte(8'h0F, d);
        chk("R3", "data ack after mismatch", {7'b0, d}, 8'h00);
        bus_stop();
        chk("R3", "ctl unchanged", ctl_q, 8'h35);
    endtask

    task automatic t_read();
        logic a, d;
        bus_start();
        send_byte({5'b11011, 2'b11, 1'b1}, a);
        chk("R4", "read address ack", {7'b0, a}, 8'h00);
        send_byte(8'h00, d);
        bus_stop();
        chk("R4", "ctl unchanged", ctl_q, 8'h35);
    endtask

    task automatic t_extra();
        logic a, d, e1, e2;
        bus_start();
        send_byte(wr_addr(2'b11), a);
        send_byte(8'hC3, d);
        send_byte(8'h5A, e1);
        send_byte(8'h00, e2);
        chk("R7", "first data ack", {7'b0, d}, 8'h01);
        chk("R7", "extra byte 1 ack", {7'b0, e1}, 8'h00);
        chk("R7", "extra byte 2 ack", {7'b0, e2}, 8'h00);
        bus_stop();
        chk("R7", "first byte kept", ctl_q, 8'hC3);
    endtask

    task automatic t_midstop();
        logic a;
        bus_start();
        send_byte(wr_addr(2'b11), a);
        send_bits(8'h00, 3);
        bus_stop();
        chk("R8", "partial byte dropped", ctl_q, 8'hC3);
    endtask

    task automatic t_restart();
        logic a, d;
        bus_start();
        send_byte(wr_addr(2'b11), a);
        send_bits(8'h11, 5);
        bus_start();
        send_byte(wr_addr(2'b11), a);
        chk("R9", "address ack after restart", {7'b0, a}, 8'h01);
        send_byte(8'h96, d);
        bus_stop();
        chk("R9", "new byte committed", ctl_q, 8'h96);
        bus_start();
        send_bits(8'hDB, 4);
        bus_start();
        send_byte(wr_addr(2'b11), a);
        chk("R9", "restart in address byte", {7'b0, a}, 8'h01);
        bus_stop();
        chk("R9", "no data, no change", ctl_q, 8'h96);
    endtask

    task automatic t_straps();
        logic a, d;
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            bus_start();
            send_byte(wr_addr(2'(s)), a);
            chk("R10", "own address ack", {7'b0, a}, 8'h01);
            send_byte(8'h10 + 8'(s), d);
            bus_stop();
            chk("R10", "strap write", ctl_q, 8'h10 + 8'(s));
            bus_start();
            send_byte(wr_addr(2'(s) ^ 2'b01), a);
            chk("R10", "other address ignored", {7'b0, a}, 8'h00);
            bus_stop();
        end
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_basic();
        t_wrong_addr();
        t_read();
        t_extra();
        t_midstop();
        t_restart();
        t_straps();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule